// File: doc/BRIEF.md
# Page-Table Refill Walker

This block services a translation miss by fetching the page-table entry that maps the missing page and handing it back to the translation buffer. When a miss is accepted, the walker derives the entry's virtual address from a page-table base value and the missing address. It asks the translation buffer to translate that address (non-recursive, at privilege 0), reads one 32-bit word from memory at the result, and then either installs the entry into one of the rotating refill ways or offers it as a temporary entry for a probe-only lookup.

Every walk ends with a single completion pulse. A successful walk returns the loaded entry and its ring, and the caller re-runs the original access through its permission check, so privilege and prohibited-access faults still apply to a freshly refilled page. If the entry address cannot be translated, the walk stops at once. No memory read is issued, and the caller's own miss cause is handed back unchanged.

Top module: `pt_refill_walker`

## Requirements
- R1: On acceptance the entry address is formed as (page-table base OR (miss address shifted right by 10)) with bits 1:0 cleared. It is presented on `xl_vaddr` together with `xl_req`, which is held until `xl_rsp_valid`.
- R2: If the entry-address translation answers with `xl_rsp_ok`=0, the next cycle carries `done_valid`=1 and `done_ok`=0, `done_cause` equals the accepted `miss_cause`, and no memory read or install takes place for that walk.
- R3: After a successful translation, `mem_req` is held with `mem_addr` equal to the returned physical address until `mem_rsp_valid`. The reported ring is bits 5:4 of the loaded word.
- R4: Each installing walk writes to way (previous way + 1) modulo 4, with the previous way equal to 0 after reset, so installs go to ways 1, 2, 3, 0, 1, and so on.
- R5: In the cycle of an install, `excv_we`=1 and `excv_data` equals the missing virtual address.
- R6: A walk accepted with `miss_probe`=1 raises `tmp_valid` instead of `inst_valid`. It does not write `excv_data` and does not advance the way rotation.
- R7: After reset the walker is idle, all request, install and completion outputs are 0, and the way rotation starts from 0.
- R8: `busy` is 1 from the cycle after acceptance up to and including the completion cycle. `miss_valid` is ignored while `busy` is 1.
- R9: A successful walk completes with `done_valid`=1, `done_ok`=1, `done_cause`=0, and `done_pte` equal to the loaded word, one cycle after the install cycle.
- R10: `done_valid` lasts one cycle, and the walker is idle (`busy`=0) in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| miss_valid | input | 1 | Miss offered; taken when not busy |
| miss_vaddr | input | VA_W | Missing virtual address |
| miss_probe | input | 1 | Probe-only walk, no buffer update |
| miss_cause | input | CAUSE_W | Miss cause returned on failure |
| pt_base | input | VA_W | Page-table base value |
| busy | output | 1 | Walk in progress |
| xl_req | output | 1 | Entry-address translation request |
| xl_vaddr | output | VA_W | Entry virtual address |
| xl_rsp_valid | input | 1 | Translation answer |
| xl_rsp_ok | input | 1 | Translation succeeded |
| xl_rsp_paddr | input | PA_W | Translated entry address |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | PA_W | Memory read address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | PTE_W | Loaded entry word |
| inst_valid | output | 1 | Install strobe |
| inst_way | output | WAY_W | Target refill way |
| inst_vaddr | output | VA_W | Virtual address of the entry |
| inst_pte | output | PTE_W | Entry word to install or use |
| inst_ring | output | RING_W | Ring of the entry |
| excv_we | output | 1 | Exception-address register write |
| excv_data | output | VA_W | Faulting virtual address |
| tmp_valid | output | 1 | Temporary entry for probe-only walk |
| done_valid | output | 1 | Walk complete |
| done_ok | output | 1 | Entry obtained; re-check the access |
| done_cause | output | CAUSE_W | Original cause on failure, else 0 |
| done_ring | output | RING_W | Ring of the loaded entry |
| done_pte | output | PTE_W | Loaded entry word |

## Verification
The bench builds the walker with its default parameters: 32-bit addresses and entries, four rotating ways, a shift of 10 and the ring field at bits 5:4. With four ways, a short series of installing walks passes through the wrap from way 3 back to way 0. Probe walks placed between the installs show whether they disturb the rotation. Translation and memory latencies from zero to several cycles cover answers that arrive in the first request cycle as well as requests that must be held.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
   typedef enum logic [2:0] {
      PTW_IDLE    = 3'd0,
      PTW_XLATE   = 3'd1,
      PTW_READ    = 3'd2,
      PTW_INSTALL = 3'd3,
      PTW_DONE    = 3'd4
   } ptw_state_e;
endpackage

// File: rtl/ptw_pte_addr.sv
module ptw_pte_addr #(
   parameter int VA_W      = 32,
   parameter int PTE_W     = 32,
   parameter int IDX_SHIFT = 10
) (
   input  logic [VA_W-1:0] pt_base,
   input  logic [VA_W-1:0] miss_va,
   output logic [VA_W-1:0] pte_va
);
   localparam int ALIGN_BITS = $clog2(PTE_W / 8);
   localparam logic [VA_W-1:0] ALIGN_MASK = ~(VA_W'((1 << ALIGN_BITS) - 1));

   if (IDX_SHIFT < 1 || IDX_SHIFT >= VA_W) begin : g_bad_shift
      initial $error("ptw_pte_addr: IDX_SHIFT out of range");
   end
   if ((PTE_W % 8) != 0) begin : g_bad_pte
      initial $error("ptw_pte_addr: PTE_W must be whole bytes");
   end

   always_comb begin
      pte_va = (pt_base | (miss_va >> IDX_SHIFT)) & ALIGN_MASK;
   end
endmodule

// File: rtl/ptw_way_ctr.sv
module ptw_way_ctr #(
   parameter int RR_WAYS = 4,
   localparam int WAY_W  = (RR_WAYS > 1) ? $clog2(RR_WAYS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             advance,
   output logic [WAY_W-1:0] nxt_way
);
   logic [WAY_W-1:0] cnt;

   if (RR_WAYS < 2) begin : g_bad_ways
      initial $error("ptw_way_ctr: RR_WAYS must be at least 2");
   end

   if ((RR_WAYS & (RR_WAYS - 1)) == 0) begin : g_pow2
      assign nxt_way = cnt + 1'b1;
   end else begin : g_mod
      assign nxt_way = (cnt == WAY_W'(RR_WAYS - 1)) ? '0 : cnt + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (advance) begin
         cnt <= nxt_way;
      end
   end
endmodule

// File: rtl/pt_refill_walker.sv
module pt_refill_walker #(
   parameter int VA_W      = 32,
   parameter int PA_W      = 32,
   parameter int PTE_W     = 32,
   parameter int CAUSE_W   = 6,
   parameter int IDX_SHIFT = 10,
   parameter int RING_LSB  = 4,
   parameter int RING_W    = 2,
   parameter int RR_WAYS   = 4,
   localparam int WAY_W    = (RR_WAYS > 1) ? $clog2(RR_WAYS) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               miss_valid,
   input  logic [VA_W-1:0]    miss_vaddr,
   input  logic               miss_probe,
   input  logic [CAUSE_W-1:0] miss_cause,
   input  logic [VA_W-1:0]    pt_base,
   output logic               busy,
   output logic               xl_req,
   output logic [VA_W-1:0]    xl_vaddr,
   input  logic               xl_rsp_valid,
   input  logic               xl_rsp_ok,
   input  logic [PA_W-1:0]    xl_rsp_paddr,
   output logic               mem_req,
   output logic [PA_W-1:0]    mem_addr,
   input  logic               mem_rsp_valid,
   input  logic [PTE_W-1:0]   mem_rsp_data,
   output logic               inst_valid,
   output logic [WAY_W-1:0]   inst_way,
   output logic [VA_W-1:0]    inst_vaddr,
   output logic [PTE_W-1:0]   inst_pte,
   output logic [RING_W-1:0]  inst_ring,
   output logic               excv_we,
   output logic [VA_W-1:0]    excv_data,
   output logic               tmp_valid,
   output logic               done_valid,
   output logic               done_ok,
   output logic [CAUSE_W-1:0] done_cause,
   output logic [RING_W-1:0]  done_ring,
   output logic [PTE_W-1:0]   done_pte
);
   import ptw_pkg::*;

   if (RING_LSB + RING_W > PTE_W) begin : g_bad_ring
      initial $error("pt_refill_walker: ring field outside entry word");
   end

   ptw_state_e         st;
   logic [VA_W-1:0]    r_va;
   logic [VA_W-1:0]    r_pte_va;
   logic               r_probe;
   logic [CAUSE_W-1:0] r_cause;
   logic [PA_W-1:0]    r_pa;
   logic [PTE_W-1:0]   r_pte;
   logic               r_ok;
   logic [VA_W-1:0]    pte_va;
   logic               way_adv;
   logic [RING_W-1:0]  ring;

   ptw_pte_addr #(
      .VA_W(VA_W), .PTE_W(PTE_W), .IDX_SHIFT(IDX_SHIFT)
   ) u_addr (
      .pt_base(pt_base),
      .miss_va(miss_vaddr),
      .pte_va (pte_va)
   );

   assign way_adv = (st == PTW_INSTALL) && !r_probe;

   ptw_way_ctr #(.RR_WAYS(RR_WAYS)) u_way (
      .clk    (clk),
      .rst_n  (rst_n),
      .advance(way_adv),
      .nxt_way(inst_way)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= PTW_IDLE;
         r_va     <= '0;
         r_pte_va <= '0;
         r_probe  <= 1'b0;
         r_cause  <= '0;
         r_pa     <= '0;
         r_pte    <= '0;
         r_ok     <= 1'b0;
      end else begin
         case (st)
            PTW_IDLE: begin
               if (miss_valid) begin
                  r_va     <= miss_vaddr;
                  r_pte_va <= pte_va;
                  r_probe  <= miss_probe;
                  r_cause  <= miss_cause;
                  r_ok     <= 1'b0;
                  st       <= PTW_XLATE;
               end
            end
            PTW_XLATE: begin
               if (xl_rsp_valid) begin
                  if (xl_rsp_ok) begin
                     r_pa <= xl_rsp_paddr;
                     st   <= PTW_READ;
                  end else begin
                     r_ok <= 1'b0;
                     st   <= PTW_DONE;
                  end
               end
            end
            PTW_READ: begin
               if (mem_rsp_valid) begin
                  r_pte <= mem_rsp_data;
                  r_ok  <= 1'b1;
                  st    <= PTW_INSTALL;
               end
            end
            PTW_INSTALL: st <= PTW_DONE;
            PTW_DONE:    st <= PTW_IDLE;
            default:     st <= PTW_IDLE;
         endcase
      end
   end

   assign ring       = r_pte[RING_LSB +: RING_W];
   assign busy       = (st != PTW_IDLE);
   assign xl_req     = (st == PTW_XLATE);
   assign xl_vaddr   = r_pte_va;
   assign mem_req    = (st == PTW_READ);
   assign mem_addr   = r_pa;
   assign inst_valid = way_adv;
   assign inst_vaddr = r_va;
   assign inst_pte   = r_pte;
   assign inst_ring  = ring;
   assign excv_we    = way_adv;
   assign excv_data  = r_va;
   assign tmp_valid  = (st == PTW_INSTALL) && r_probe;
   assign done_valid = (st == PTW_DONE);
   assign done_ok    = (st == PTW_DONE) && r_ok;
   assign done_cause = (st == PTW_DONE && !r_ok) ? r_cause : '0;
   assign done_ring  = ring;
   assign done_pte   = r_pte;
endmodule

// File: rtl/pt_refill_walker_chk.sv
module pt_refill_walker_chk #(
   parameter int VA_W    = 32,
   parameter int PA_W    = 32,
   parameter int RR_WAYS = 4,
   localparam int WAY_W  = (RR_WAYS > 1) ? $clog2(RR_WAYS) : 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             busy,
   input logic             xl_req,
   input logic             xl_rsp_valid,
   input logic             xl_rsp_ok,
   input logic             mem_req,
   input logic [PA_W-1:0]  mem_addr,
   input logic             mem_rsp_valid,
   input logic             inst_valid,
   input logic [WAY_W-1:0] inst_way,
   input logic [VA_W-1:0]  inst_vaddr,
   input logic             excv_we,
   input logic [VA_W-1:0]  excv_data,
   input logic             tmp_valid,
   input logic             done_valid,
   input logic             done_ok
);
   logic [WAY_W-1:0] last_way;
   logic [WAY_W-1:0] want_way;

   assign want_way = (last_way == WAY_W'(RR_WAYS - 1)) ? '0 : last_way + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          last_way <= '0;
      else if (inst_valid) last_way <= inst_way;
   end

   // R8
   phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({xl_req, mem_req, inst_valid, tmp_valid, done_valid}));

   // R2
   xl_fail_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (xl_req && xl_rsp_valid && !xl_rsp_ok) |=> (done_valid && !done_ok));

   // R3
   mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_rsp_valid) |=> (mem_req && $stable(mem_addr)));

   // R4
   way_rotate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      inst_valid |-> (inst_way == want_way));

   // R5
   excv_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      inst_valid |-> (excv_we && excv_data == inst_vaddr));

   // R6
   probe_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tmp_valid |-> (!inst_valid && !excv_we));

   // R8
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done_valid) |=> busy);

   // R10
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |=> !busy);
endmodule

bind pt_refill_walker pt_refill_walker_chk #(
   .VA_W(VA_W), .PA_W(PA_W), .RR_WAYS(RR_WAYS)
) u_chk (.*);

// File: tb/pt_refill_walker_bench.sv
module pt_refill_walker_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        miss_valid = 1'b0;
   logic [31:0] miss_vaddr = '0;
   logic        miss_probe = 1'b0;
   logic [5:0]  miss_cause = '0;
   logic [31:0] pt_base = '0;
   logic        busy, xl_req, mem_req, inst_valid, excv_we, tmp_valid;
   logic        done_valid, done_ok;
   logic [31:0] xl_vaddr, mem_addr, inst_vaddr, inst_pte, excv_data, done_pte;
   logic        xl_rsp_valid = 1'b0, xl_rsp_ok = 1'b0, mem_rsp_valid = 1'b0;
   logic [31:0] xl_rsp_paddr = '0, mem_rsp_data = '0;
   logic [1:0]  inst_way, inst_ring, done_ring;
   logic [5:0]  done_cause;

   int n_tests = 0, n_fail = 0, cycles = 0;
   bit finished = 0;

   int xl_lat = 0, mem_lat = 0, xl_cnt = 0, mem_cnt = 0;
   bit xl_ok_cfg = 1;
   logic [31:0] xl_pa_cfg = '0, mem_data_cfg = '0;
   int ways_seen[$];

   // reference model state
   int          m_st = 0;  // 0 idle 1 xlate 2 read 3 install 4 done
   logic [31:0] m_va, m_pva, m_pa, m_pte;
   logic        m_probe, m_ok;
   logic [5:0]  m_cause;
   int          m_last = 0;

   always #10 clk = ~clk;

   pt_refill_walker u_pt_refill_walker (.*);

   task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // reference model, advanced on the same edge the design uses
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_st = 0; m_last = 0; m_ok = 0;
      end else begin
         case (m_st)
            0: if (miss_valid) begin
                  m_va = miss_vaddr; m_probe = miss_probe; m_cause = miss_cause;
                  m_pva = (pt_base | (miss_vaddr >> 10)) & 32'hFFFF_FFFC;
                  m_ok = 0; m_st = 1;
               end
            1: if (xl_rsp_valid) begin
                  if (xl_rsp_ok) begin m_pa = xl_rsp_paddr; m_st = 2; end
                  else begin m_ok = 0; m_st = 4; end
               end
            2: if (mem_rsp_valid) begin m_pte = mem_rsp_data; m_ok = 1; m_st = 3; end
            3: begin
                  if (!m_probe) m_last = (m_last + 1) % 4;
                  m_st = 4;
               end
            default: m_st = 0;
         endcase
      end
   end

   // compare every clock, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         chk("R8", "busy", busy, m_st != 0);
         chk("R1", "xl_req", xl_req, m_st == 1);
         if (m_st == 1) chk("R1", "xl_vaddr", xl_vaddr, m_pva);
         chk("R3", "mem_req", mem_req, m_st == 2);
         if (m_st == 2) chk("R3", "mem_addr", mem_addr, m_pa);
         chk("R4", "inst_valid", inst_valid, m_st == 3 && !m_probe);
         chk("R5", "excv_we", excv_we, m_st == 3 && !m_probe);
         chk("R6", "tmp_valid", tmp_valid, m_st == 3 && m_probe);
         if (m_st == 3 && !m_probe) begin
            chk("R4", "inst_way", inst_way, (m_last + 1) % 4);
            chk("R5", "excv_data", excv_data, m_va);
            chk("R3", "inst_ring", inst_ring, m_pte[5:4]);
            ways_seen.push_back(int'(inst_way));
         end
         if (m_st == 3 && m_probe) chk("R6", "tmp_pte", inst_pte, m_pte);
         chk("R10", "done_valid", done_valid, m_st == 4);
         if (m_st == 4) begin
            chk("R9", "done_ok", done_ok, m_ok);
            chk(m_ok ? "R9" : "R2", "done_cause", done_cause, m_ok ? 6'd0 : m_cause);
            if (m_ok) begin
               chk("R9", "done_pte", done_pte, m_pte);
               chk("R3", "done_ring", done_ring, m_pte[5:4]);
            end
         end
      end
   end

   // translation and memory responders
   always @(negedge clk) begin
      xl_rsp_valid = 0; mem_rsp_valid = 0;
      if (xl_req) begin
         if (xl_cnt == xl_lat) begin
            xl_rsp_valid = 1; xl_rsp_ok = xl_ok_cfg; xl_rsp_paddr = xl_pa_cfg; xl_cnt = 0;
         end else xl_cnt++;
      end else xl_cnt = 0;
      if (mem_req) begin
         if (mem_cnt == mem_lat) begin
            mem_rsp_valid = 1; mem_rsp_data = mem_data_cfg; mem_cnt = 0;
         end else mem_cnt++;
      end else mem_cnt = 0;
   end

   task automatic finish_run();
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000 && !finished) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: run did not end (actual=hung expected=done)");
         finish_run();
      end
   end

   task automatic walk(input logic [31:0] va, input bit probe, input logic [5:0] cause,
                       input bit ok, input logic [31:0] pa, input logic [31:0] pte,
                       input int xl_l, input int mem_l, input bit poke);
      xl_lat = xl_l; mem_lat = mem_l; xl_ok_cfg = ok; xl_pa_cfg = pa; mem_data_cfg = pte;
      @(negedge clk);
      miss_valid = 1; miss_vaddr = va; miss_probe = probe; miss_cause = cause;
      @(negedge clk);
      miss_valid = 0;
      if (poke) begin
         // R8: a second miss offered while busy must be ignored
         miss_valid = 1; miss_vaddr = 32'hDEAD_0000; miss_probe = 0;
         @(negedge clk);
         miss_valid = 0;
      end
      while (busy) @(negedge clk);
      @(negedge clk);
      chk("R8", "idle after walk", busy, 1'b0);
   endtask

   initial begin
      pt_base = 32'h8000_0000;
      repeat (3) @(negedge clk);
      // R7: reset state
      chk("R7", "busy", busy, 0);
      chk("R7", "outputs", {xl_req, mem_req, inst_valid, tmp_valid, done_valid, excv_we}, 0);
      rst_n = 1;
      @(negedge clk);
      chk("R7", "idle after release", busy, 0);

      walk(32'h1234_5678, 0, 6'd24, 1, 32'h0040_1000, 32'h0ABC_D013, 0, 0, 0);
      walk(32'hFFFF_F003, 1, 6'd24, 1, 32'h0040_2000, 32'h1111_1120, 2, 3, 0);
      walk(32'h0000_0C00, 0, 6'd16, 0, 32'h0, 32'h0, 1, 0, 0);
      walk(32'h4000_1000, 0, 6'd24, 1, 32'h0040_3004, 32'h2222_2230, 3, 1, 1);
      pt_base = 32'h0040_0000;
      walk(32'h7FFF_FFFF, 0, 6'd24, 1, 32'h0040_4008, 32'h3333_3300, 0, 4, 0);
      walk(32'h0000_0000, 1, 6'd16, 0, 32'h0, 32'h0, 0, 0, 1);
      walk(32'hA5A5_A5A5, 0, 6'd24, 1, 32'h0040_500C, 32'h4444_4410, 1, 1, 0);
      walk(32'h5A5A_5A5A, 0, 6'd24, 1, 32'h0040_6000, 32'h5555_5520, 0, 2, 0);

      // R4: independent view of the rotation; probes and failures skip it
      chk("R4", "install count", ways_seen.size(), 5);
      foreach (ways_seen[i]) chk("R4", "way order", ways_seen[i], (i + 1) % 4);

      // R7: reset again puts rotation back to 0 so the next install uses way 1
      @(negedge clk); rst_n = 0;
      @(negedge clk); rst_n = 1;
      ways_seen.delete();
      walk(32'h0101_0101, 0, 6'd24, 1, 32'h0040_7000, 32'h6666_6630, 0, 0, 0);
      chk("R7", "first way after reset", ways_seen.size() == 1 ? ways_seen[0] : -1, 1);

      finish_run();
   end
endmodule